// File: doc/BRIEF.md
# Fuse Store with Security Lock

This block holds the configuration pattern of a small programmable logic array. A word-addressed programming port reaches it, and the whole pattern is exported in parallel to the array. The port takes one command per valid strobe. It can burn fuse bits, read a fuse word back for verification, erase everything, read and write a 64-bit user signature, ask the array to preload its output registers with a chosen value, or set a security bit.

Once the security bit is set, it blocks verify reads and preload requests from the very next command. The signature area stays fully usable in that state. The only way to clear the security bit is a full erase, which also returns every fuse and every signature bit to the erased level. Each command is answered on the cycle after its strobe. The answer carries an acknowledge, a read word, and a flag that marks a command refused by the lock.

Top module: `fuse_store`

## Requirements
- R1: Every cycle with `valid` high produces `ack` high on the following cycle. A cycle with `valid` low produces `ack` low on the following cycle. `ack` is low after reset.
- R2: Command 1 (fuse write) ANDs `wdata` into the addressed fuse word. Bits can only go from 1 to 0, and writing a 1 over a 0 leaves the 0 in place.
- R3: Command 2 (fuse verify) returns the addressed fuse word on `rdata` with `locked` low while the device is unsecured.
- R4: Command 2 issued while secured returns all zeros on `rdata` with `locked` high.
- R5: Command 6 (preload) issued while unsecured pulses `preload_stb` for one cycle, together with the response. It sets `preload_val` to `wdata[OUT_REGS-1:0]`, each bit chosen independently. Issued while secured, it produces no pulse, leaves `preload_val` unchanged and raises `locked`.
- R6: Command 7 (secure) sets the security bit, and the very next command already sees it.
- R7: Command 4 (signature write) overwrites signature word `addr` modulo 64/DATA_W. Command 5 (signature read) returns that word with `locked` low. Both work the same whether or not the device is secured.
- R8: Command 3 (erase) sets every fuse bit and every signature bit to 1 and clears the security bit.
- R9: After reset all fuse and signature bits are 1, the device is unsecured, and `rdata`, `locked` and `preload_stb` are low.
- R10: `fuse_map` word i (bits i*DATA_W and up) shows the stored fuse word i. A write is visible there on the same cycle as its `ack`. Commands 0, 1, 3, 4, 6 and 7 return zero on `rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| valid | input | 1 | Command strobe, one command per high cycle |
| cmd | input | 3 | Command code |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data or preload value |
| ack | output | 1 | Response strobe, one cycle after `valid` |
| rdata | output | DATA_W | Read result, zero for commands that do not read or are refused |
| locked | output | 1 | Command refused by the security bit |
| fuse_map | output | FUSE_WORDS*DATA_W | Whole fuse pattern for the logic array |
| preload_stb | output | 1 | One-cycle preload request to the logic array |
| preload_val | output | OUT_REGS | Value to load into the output registers |

## Verification
All results are due exactly one clock after the edge that samples `valid`. This covers `ack`, `rdata`, `locked`, `preload_stb`, `preload_val`, the updated `fuse_map` and the new lock state. The bench drives each command on a falling edge and removes it on the next falling edge. It samples every output at that second falling edge, which is half a period after the edge that registered the response. Commands are separated by one idle cycle, so a missing or extra `ack` shows up as a mismatch at a fixed sample point. The secure-then-read sequence checks that the lock holds from the very next command without any reset between them.

// File: rtl/fuse_store_pkg.sv
package fuse_store_pkg;

  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_FUSE_WR = 3'd1,
    OP_FUSE_RD = 3'd2,
    OP_ERASE   = 3'd3,
    OP_SIG_WR  = 3'd4,
    OP_SIG_RD  = 3'd5,
    OP_PRELOAD = 3'd6,
    OP_SECURE  = 3'd7
  } op_e;

  // one action strobe per accepted command
  typedef struct packed {
    logic fz_wr;
    logic fz_rd;
    logic rd_deny;
    logic erase;
    logic sig_wr;
    logic sig_rd;
    logic pl_go;
    logic pl_deny;
    logic lock_set;
  } act_t;

  localparam int SIG_BITS = 64;

endpackage

// File: rtl/fuse_cmd_decode.sv
module fuse_cmd_decode
  import fuse_store_pkg::*;
(
  input  logic       valid,
  input  logic [2:0] cmd,
  input  logic       secured,
  output act_t       act
);

  op_e op;
  assign op = op_e'(cmd);

  always_comb begin
    act = '0;
    if (valid) begin
      case (op)
        OP_FUSE_WR: act.fz_wr    = 1'b1;
        OP_FUSE_RD: begin
          act.fz_rd   = !secured;
          act.rd_deny = secured;
        end
        OP_ERASE:   act.erase    = 1'b1;
        OP_SIG_WR:  act.sig_wr   = 1'b1;
        OP_SIG_RD:  act.sig_rd   = 1'b1;
        OP_PRELOAD: begin
          act.pl_go   = !secured;
          act.pl_deny = secured;
        end
        OP_SECURE:  act.lock_set = 1'b1;
        default:    act = '0;
      endcase
    end
  end

endmodule

// File: rtl/fuse_array.sv
module fuse_array #(
  parameter int WORDS  = 16,
  parameter int DW     = 16,
  parameter int AW     = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                erase,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wdata,
  output logic [DW-1:0]       rd_word,
  output logic [WORDS*DW-1:0] map
);

  // burning can only remove ones
  function automatic logic [DW-1:0] burn(input logic [DW-1:0] old_w,
                                         input logic [DW-1:0] new_w);
    return old_w & new_w;
  endfunction

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic [DW-1:0] cell_q;
    logic          hit;
    assign hit = wr_en && (addr == AW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cell_q <= '1;
      else if (erase)  cell_q <= '1;
      else if (hit)    cell_q <= burn(cell_q, wdata);
    end

    assign map[i*DW +: DW] = cell_q;

    AST_BITS_ONLY_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !erase |=> ((cell_q & ~$past(cell_q)) == '0)); // R2
  end

  assign rd_word = map[addr*DW +: DW];

endmodule

// File: rtl/fuse_sig_area.sv
module fuse_sig_area #(
  parameter int DW = 16,
  parameter int SW = 4,
  parameter int SAW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic           erase,
  input  logic [SAW-1:0] addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rd_word
);

  logic [DW-1:0] sig_q [SW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SW; i++) sig_q[i] <= '1;
    end else if (erase) begin
      for (int i = 0; i < SW; i++) sig_q[i] <= '1;
    end else if (wr_en) begin
      sig_q[addr] <= wdata;
    end
  end

  assign rd_word = sig_q[addr];

  AST_SIG_TAKES_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !erase) |=> (sig_q[$past(addr)] == $past(wdata))); // R7

endmodule

// File: rtl/fuse_store.sv
module fuse_store
  import fuse_store_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FUSE_WORDS = 16,
  parameter int OUT_REGS   = 8,
  parameter int ADDR_W     = (FUSE_WORDS > 1) ? $clog2(FUSE_WORDS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         valid,
  input  logic [2:0]                   cmd,
  input  logic [ADDR_W-1:0]            addr,
  input  logic [DATA_W-1:0]            wdata,
  output logic                         ack,
  output logic [DATA_W-1:0]            rdata,
  output logic                         locked,
  output logic [FUSE_WORDS*DATA_W-1:0] fuse_map,
  output logic                         preload_stb,
  output logic [OUT_REGS-1:0]          preload_val
);

  localparam int SIG_WORDS = SIG_BITS / DATA_W;
  localparam int SIG_AW    = (SIG_WORDS > 1) ? $clog2(SIG_WORDS) : 1;

  // named internal events
  act_t            act;
  logic            secured_q;
  logic [DATA_W-1:0] fuse_word;
  logic [DATA_W-1:0] sig_word;
  logic [DATA_W-1:0] rd_sel;
  logic            refused;

  fuse_cmd_decode u_dec (
    .valid   (valid),
    .cmd     (cmd),
    .secured (secured_q),
    .act     (act)
  );

  fuse_array #(.WORDS(FUSE_WORDS), .DW(DATA_W), .AW(ADDR_W)) u_fuses (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (act.fz_wr),
    .erase   (act.erase),
    .addr    (addr),
    .wdata   (wdata),
    .rd_word (fuse_word),
    .map     (fuse_map)
  );

  fuse_sig_area #(.DW(DATA_W), .SW(SIG_WORDS), .SAW(SIG_AW)) u_sig (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (act.sig_wr),
    .erase   (act.erase),
    .addr    (addr[SIG_AW-1:0]),
    .wdata   (wdata),
    .rd_word (sig_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            secured_q <= 1'b0;
    else if (act.erase)    secured_q <= 1'b0;
    else if (act.lock_set) secured_q <= 1'b1;
  end

  always_comb begin
    rd_sel = '0;
    if (act.fz_rd)       rd_sel = fuse_word;
    else if (act.sig_rd) rd_sel = sig_word;
  end

  assign refused = act.rd_deny | act.pl_deny;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack         <= 1'b0;
      rdata       <= '0;
      locked      <= 1'b0;
      preload_stb <= 1'b0;
      preload_val <= '0;
    end else begin
      ack         <= valid;
      rdata       <= rd_sel;
      locked      <= refused;
      preload_stb <= act.pl_go;
      if (act.pl_go) preload_val <= wdata[OUT_REGS-1:0];
    end
  end

  AST_ACK_AFTER_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> ack); // R1
  AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> !ack); // R1
  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(act)); // R1
  AST_LOCKED_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && locked) |-> (rdata == '0)); // R4
  AST_SECURED_NO_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (secured_q && valid && cmd == OP_PRELOAD) |=> (!preload_stb && locked && $stable(preload_val))); // R5
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (secured_q && !(valid && cmd == OP_ERASE)) |=> secured_q); // R6
  AST_SECURE_AT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && cmd == OP_SECURE) |=> secured_q); // R6
  AST_ERASE_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && cmd == OP_ERASE) |=> (!secured_q && (fuse_map == '1))); // R8

endmodule

// File: tb/test_fuse_store.sv
module test_fuse_store;

  localparam int DW = 16;
  localparam int FW = 16;
  localparam int OR = 8;
  localparam int AW = 4;
  localparam int VW = 3 + AW + DW + DW + 1 + 1;
  localparam int NV = 19;

  // {cmd, addr, wdata, expected rdata, expected locked, expected preload pulse}
  localparam logic [VW-1:0] VEC [NV] = '{
    {3'd1, 4'd3, 16'hF0F0, 16'h0000, 1'b0, 1'b0}, // R2 burn
    {3'd2, 4'd3, 16'h0000, 16'hF0F0, 1'b0, 1'b0}, // R3
    {3'd1, 4'd3, 16'h3C3C, 16'h0000, 1'b0, 1'b0}, // R2 AND
    {3'd2, 4'd3, 16'h0000, 16'h3030, 1'b0, 1'b0}, // R2
    {3'd1, 4'd3, 16'hFFFF, 16'h0000, 1'b0, 1'b0}, // R2 no restore
    {3'd2, 4'd3, 16'h0000, 16'h3030, 1'b0, 1'b0}, // R2
    {3'd4, 4'd1, 16'h1234, 16'h0000, 1'b0, 1'b0}, // R7
    {3'd5, 4'd1, 16'h0000, 16'h1234, 1'b0, 1'b0}, // R7
    {3'd2, 4'd5, 16'h0000, 16'hFFFF, 1'b0, 1'b0}, // R9 untouched word
    {3'd6, 4'd0, 16'h00A5, 16'h0000, 1'b0, 1'b1}, // R5 allowed
    {3'd7, 4'd0, 16'h0000, 16'h0000, 1'b0, 1'b0}, // R6 secure
    {3'd2, 4'd3, 16'h0000, 16'h0000, 1'b1, 1'b0}, // R4 and R6
    {3'd5, 4'd1, 16'h0000, 16'h1234, 1'b0, 1'b0}, // R7 secured
    {3'd4, 4'd1, 16'hABCD, 16'h0000, 1'b0, 1'b0}, // R7 secured
    {3'd5, 4'd1, 16'h0000, 16'hABCD, 1'b0, 1'b0}, // R7
    {3'd6, 4'd0, 16'h005A, 16'h0000, 1'b1, 1'b0}, // R5 refused
    {3'd3, 4'd0, 16'h0000, 16'h0000, 1'b0, 1'b0}, // R8 erase
    {3'd2, 4'd3, 16'h0000, 16'hFFFF, 1'b0, 1'b0}, // R8
    {3'd5, 4'd1, 16'h0000, 16'hFFFF, 1'b0, 1'b0}  // R8
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              valid = 1'b0;
  logic [2:0]        cmd = '0;
  logic [AW-1:0]     addr = '0;
  logic [DW-1:0]     wdata = '0;
  logic              ack;
  logic [DW-1:0]     rdata;
  logic              locked;
  logic [FW*DW-1:0]  fuse_map;
  logic              preload_stb;
  logic [OR-1:0]     preload_val;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  fuse_store i_fuse_store (
    .clk(clk), .rst_n(rst_n), .valid(valid), .cmd(cmd), .addr(addr),
    .wdata(wdata), .ack(ack), .rdata(rdata), .locked(locked),
    .fuse_map(fuse_map), .preload_stb(preload_stb), .preload_val(preload_val)
  );

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // drive on a falling edge, sample at the next falling edge
  task automatic issue(input logic [2:0] c, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    valid = 1'b1; cmd = c; addr = a; wdata = d;
    @(negedge clk);
    valid = 1'b0; cmd = '0; addr = '0; wdata = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check("R9 ack", 256'(ack), 256'(0));
    check("R9 rdata", 256'(rdata), 256'(0));
    check("R9 locked", 256'(locked), 256'(0));
    check("R9 preload_stb", 256'(preload_stb), 256'(0));
    check("R9 fuse_map", 256'(fuse_map), {256{1'b1}});
    @(negedge clk);
    check("R1 idle no ack", 256'(ack), 256'(0));

    for (int k = 0; k < NV; k++) begin
      logic [2:0]    vc;
      logic [AW-1:0] va;
      logic [DW-1:0] vd;
      logic [DW-1:0] er;
      logic          el;
      logic          ep;
      {vc, va, vd, er, el, ep} = VEC[k];
      issue(vc, va, vd);
      check("R1 ack", 256'(ack), 256'(1));
      check(el ? "R4/R5 rdata" : "R3/R7 rdata", 256'(rdata), 256'(er));
      check("R4/R5 locked", 256'(locked), 256'(el));
      check("R5 preload_stb", 256'(preload_stb), 256'(ep));
      if (ep) check("R5 preload_val", 256'(preload_val), 256'(vd[OR-1:0]));
      if (vc == 3'd6 && !ep) check("R5 preload_val held", 256'(preload_val), 256'(8'hA5));
      @(negedge clk);
      check("R1 ack drops", 256'(ack), 256'(0));
    end

    // after erase: whole pattern back to ones, unsecured
    check("R8 fuse_map", 256'(fuse_map), {256{1'b1}});
    issue(3'd6, '0, 16'h003C);
    check("R8 preload after erase", 256'(preload_stb), 256'(1));
    check("R5 independent bits", 256'(preload_val), 256'(8'h3C));

    // export of a burned word on the cycle of its ack
    issue(3'd1, 4'd7, 16'h0F00);
    check("R10 fuse_map word", 256'(fuse_map[7*DW +: DW]), 256'(16'h0F00));
    check("R10 write rdata zero", 256'(rdata), 256'(0));
    check("R10 other word", 256'(fuse_map[6*DW +: DW]), 256'(16'hFFFF));

    // signature address wraps modulo the signature word count
    issue(3'd4, 4'd6, 16'h5A5A);
    issue(3'd5, 4'd2, 16'h0000);
    check("R7 sig wrap", 256'(rdata), 256'(16'h5A5A));

    // secure then preload immediately
    issue(3'd7, '0, '0);
    issue(3'd6, '0, 16'h00FF);
    check("R6 immediate lock", 256'(locked), 256'(1));
    check("R6 no preload", 256'(preload_stb), 256'(0));
    check("R5 value kept", 256'(preload_val), 256'(8'h3C));

    // back-to-back valid cycles
    @(negedge clk);
    valid = 1'b1; cmd = 3'd0;
    @(negedge clk);
    check("R1 nop ack", 256'(ack), 256'(1));
    check("R10 nop rdata", 256'(rdata), 256'(0));
    @(negedge clk);
    valid = 1'b0;
    check("R1 second ack", 256'(ack), 256'(1));
    @(negedge clk);
    check("R1 ack low", 256'(ack), 256'(0));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule